// File: doc/BRIEF.md
# Slice-Side Compute Request Sequencer

This block is a control state machine that sits beside one slice of a shared last-level cache. It is attached to three synchronous SRAM arrays: the slice's data array, a compute-capable array that works on whole 512-bit rows, and a command memory of 16-bit micro-commands. It accepts one request at a time, coded in three bits. There are four kinds of work. It can place a single 32-bit word into the compute array. It can copy a whole cache line from the data array into the compute array. It can copy a line into the command memory. It can run an algorithm by replaying the stored command stream.

Line copies first look at the slice tag result. On a miss they wait for the refill return before they read the line. The copy is a read of the data array followed at once by a write into the destination array. An execution request replays commands from the command memory to the compute array, one command per cycle. It then reads the compute row selected by the request address and writes that row back into the data array at the same address. Every request ends with a one-cycle completion pulse, and the block then returns to idle.

Top module: `nsc_sequencer`

## Requirements
- R1: After reset all nine array strobes (chip select, write enable and output enable of each array, all active low) are high, `done` is low and `cmp_cmd_vld` is low.
- R2: Request code 0 is a word store, 1 a line copy into the compute array and 2 a command load. Codes 3 to 7 run an algorithm, and while commands stream `cmp_alg` shows the code minus 3.
- R3: A word store writes the compute array in the cycle after acceptance. The row is the store pointer bits [11:4]. `cmp_wmask` is one-hot at lane pointer bits [3:0], and the word is replicated across all 16 lanes. The data array is left untouched. The pointer starts at 0, advances by one on each store and wraps after 4095.
- R4: For a copy or a command load, the cycle after acceptance samples `tag_hit`. A hit reads the data array in the next cycle. A miss keeps every data array strobe high until the cycle after `miss_ret` is seen high.
- R5: A line copy reads the data array at `req_addr` in one cycle. In the next cycle it writes the 512-bit line into compute row `req_addr[7:0]` with all lanes enabled.
- R6: A command load writes the fetched line into the command memory at address slot*32. The slot starts at 0, advances by one per load (holding at the last slot) and returns to 0 when an execution completes.
- R7: The count stored by a command load is `req_count`, clipped to 8192.
- R8: Execution reads command addresses 0 to count-1 in consecutive cycles, starting the cycle after acceptance. Each read command appears on `cmp_cmd` with `cmp_cmd_vld` high in the following cycle. A count of zero reads no command.
- R9: One cycle after the last command is presented, compute row `req_addr[7:0]` is read. The next cycle writes the data array at `req_addr` with the row's contents.
- R10: `done` is high for exactly one cycle, the cycle after the request's last array access. A request presented while the block is busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; taken only when idle |
| req_code | input | 3 | Request kind (see R2) |
| req_addr | input | 16 | Line address of the request |
| req_wdata | input | 32 | Word for a store |
| req_count | input | 16 | Command count for a command load |
| tag_hit | input | 1 | Slice tag lookup hit |
| miss_ret | input | 1 | Refill of a missed line has returned |
| dat_csb | output | 1 | Data array chip select, active low |
| dat_web | output | 1 | Data array write enable, active low |
| dat_oeb | output | 1 | Data array output enable, active low |
| dat_addr | output | 16 | Data array line address |
| dat_wdata | output | 512 | Data array write line |
| dat_rdata | input | 512 | Data array read line, valid one cycle after read |
| cmp_csb | output | 1 | Compute array chip select, active low |
| cmp_web | output | 1 | Compute array write enable, active low |
| cmp_oeb | output | 1 | Compute array output enable, active low |
| cmp_addr | output | 8 | Compute array row |
| cmp_wmask | output | 16 | Compute array 32-bit lane enables |
| cmp_wdata | output | 512 | Compute array write row |
| cmp_rdata | input | 512 | Compute array read row, valid one cycle after read |
| cmp_cmd | output | 16 | Command presented to the compute array |
| cmp_cmd_vld | output | 1 | `cmp_cmd` is valid this cycle |
| cmp_alg | output | 3 | Algorithm index during execution |
| cma_csb | output | 1 | Command memory chip select, active low |
| cma_web | output | 1 | Command memory write enable, active low |
| cma_oeb | output | 1 | Command memory output enable, active low |
| cma_addr | output | 13 | Command memory address, in commands |
| cma_wdata | output | 512 | Command memory write line |
| cma_rdata | input | 16 | Command memory read word, valid one cycle after read |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench holds a request valid while a store is still in flight. A sequencer that accepts outside idle would then start a tag check and read the data array. A miss is left pending for several cycles, which catches a design that reads the line before the refill returns or that skips the tag check. Execution is run with a count of zero, a count of five and a count clipped from 20000 down to 8192. A wrong stop condition shows up as a missing or an extra command, and a wrong pointer reset shows up as a replay that does not start at address zero. Loads are issued both before and after an execution to expose a load slot that never rewinds, and the store pointer is driven through its wrap from 4095 back to 0.

// File: rtl/nsc_pkg.sv
package nsc_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_STORE,
        S_TAG,
        S_WAIT,
        S_RD,
        S_WR,
        S_RUN,
        S_RES_RD,
        S_RES_WR,
        S_DONE
    } seq_state_e;

    localparam logic [2:0] OP_STORE    = 3'd0;
    localparam logic [2:0] OP_COPY     = 3'd1;
    localparam logic [2:0] OP_CMDLD    = 3'd2;
    localparam logic [2:0] OP_ALG_BASE = 3'd3;

endpackage

// File: rtl/nsc_store_ctr.sv
module nsc_store_ctr #(
    parameter int AW   = 12,
    parameter int BASE = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    output logic [AW-1:0] ptr
);

    logic [AW-1:0] ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (step) ptr_d = ptr_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= AW'(BASE);
        else        ptr_q <= ptr_d;
    end

    assign ptr = ptr_q;

    // R3
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(ptr_q));

endmodule

// File: rtl/nsc_cmd_stream.sv
module nsc_cmd_stream #(
    parameter int CNT_W   = 14,
    parameter int SLOT_AW = 8,
    parameter int DEPTH   = 8192
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_en,
    input  logic [CNT_W-1:0]   load_cnt,
    input  logic               run_start,
    input  logic               run_act,
    input  logic               run_end,
    output logic [CNT_W-1:0]   ptr,
    output logic [SLOT_AW-1:0] slot,
    output logic               more,
    output logic               vld
);

    localparam logic [SLOT_AW-1:0] SLOT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0]   cnt;
        logic [CNT_W-1:0]   ptr;
        logic [SLOT_AW-1:0] slot;
        logic               vld;
    } stream_t;

    stream_t s_d, s_q;
    logic    rd;

    assign more = (s_q.ptr < s_q.cnt);
    assign rd   = run_act && more;

    always_comb begin
        s_d     = s_q;
        s_d.vld = rd;
        if (rd)        s_d.ptr = s_q.ptr + 1'b1;
        if (run_start) s_d.ptr = '0;
        if (load_en) begin
            s_d.cnt = load_cnt;
            s_d.ptr = '0;
            if (s_q.slot != SLOT_MAX) s_d.slot = s_q.slot + 1'b1;
        end
        if (run_end) s_d.slot = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ptr  = s_q.ptr;
    assign slot = s_q.slot;
    assign vld  = s_q.vld;

    // R8
    ptr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.ptr <= s_q.cnt);

    // R7
    cnt_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= CNT_W'(DEPTH));

endmodule

// File: rtl/nsc_sequencer.sv
module nsc_sequencer
    import nsc_pkg::*;
#(
    parameter int LINE_W     = 512,
    parameter int WORD_W     = 32,
    parameter int CMD_W      = 16,
    parameter int CMD_DEPTH  = 8192,
    parameter int ROWS       = 256,
    parameter int LINE_AW    = 16,
    parameter int CNT_IN_W   = 16,
    parameter int STORE_BASE = 0,
    localparam int LANES     = LINE_W / WORD_W,
    localparam int LANE_AW   = $clog2(LANES),
    localparam int ROW_AW    = $clog2(ROWS),
    localparam int CMD_AW    = $clog2(CMD_DEPTH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [2:0]          req_code,
    input  logic [LINE_AW-1:0]  req_addr,
    input  logic [WORD_W-1:0]   req_wdata,
    input  logic [CNT_IN_W-1:0] req_count,
    input  logic                tag_hit,
    input  logic                miss_ret,
    output logic                dat_csb,
    output logic                dat_web,
    output logic                dat_oeb,
    output logic [LINE_AW-1:0]  dat_addr,
    output logic [LINE_W-1:0]   dat_wdata,
    input  logic [LINE_W-1:0]   dat_rdata,
    output logic                cmp_csb,
    output logic                cmp_web,
    output logic                cmp_oeb,
    output logic [ROW_AW-1:0]   cmp_addr,
    output logic [LANES-1:0]    cmp_wmask,
    output logic [LINE_W-1:0]   cmp_wdata,
    input  logic [LINE_W-1:0]   cmp_rdata,
    output logic [CMD_W-1:0]    cmp_cmd,
    output logic                cmp_cmd_vld,
    output logic [2:0]          cmp_alg,
    output logic                cma_csb,
    output logic                cma_web,
    output logic                cma_oeb,
    output logic [CMD_AW-1:0]   cma_addr,
    output logic [LINE_W-1:0]   cma_wdata,
    input  logic [CMD_W-1:0]    cma_rdata,
    output logic                done
);

    localparam int ST_AW   = ROW_AW + LANE_AW;
    localparam int CNT_W   = CMD_AW + 1;
    localparam int CPL     = LINE_W / CMD_W;
    localparam int CPL_AW  = $clog2(CPL);
    localparam int SLOT_AW = CMD_AW - CPL_AW;

    typedef struct packed {
        seq_state_e         st;
        logic               is_load;
        logic [LINE_AW-1:0] addr;
        logic [WORD_W-1:0]  wdata;
        logic [CNT_W-1:0]   cnt;
        logic [2:0]         alg;
    } seq_t;

    seq_t r_d, r_q;

    logic               st_step, ld_en, run_start, run_end, run_act, rd_go;
    logic [ST_AW-1:0]   sp;
    logic [CNT_W-1:0]   cptr;
    logic [SLOT_AW-1:0] slot;
    logic               more, cvld;
    logic [CNT_W-1:0]   clip;

    nsc_store_ctr #(.AW(ST_AW), .BASE(STORE_BASE)) u_store (
        .clk(clk), .rst_n(rst_n), .step(st_step), .ptr(sp)
    );

    nsc_cmd_stream #(.CNT_W(CNT_W), .SLOT_AW(SLOT_AW), .DEPTH(CMD_DEPTH)) u_stream (
        .clk(clk), .rst_n(rst_n), .load_en(ld_en), .load_cnt(r_q.cnt),
        .run_start(run_start), .run_act(run_act), .run_end(run_end),
        .ptr(cptr), .slot(slot), .more(more), .vld(cvld)
    );

    assign run_act     = (r_q.st == S_RUN);
    assign rd_go       = run_act && more;
    assign clip        = (req_count > CNT_IN_W'(CMD_DEPTH)) ? CNT_W'(CMD_DEPTH)
                                                            : CNT_W'(req_count);
    assign cmp_cmd     = cma_rdata;
    assign cmp_cmd_vld = cvld;

    always_comb begin
        r_d       = r_q;
        st_step   = 1'b0;
        ld_en     = 1'b0;
        run_start = 1'b0;
        run_end   = 1'b0;
        done      = 1'b0;
        dat_csb   = 1'b1;
        dat_web   = 1'b1;
        dat_oeb   = 1'b1;
        dat_addr  = r_q.addr;
        dat_wdata = cmp_rdata;
        cmp_csb   = 1'b1;
        cmp_web   = 1'b1;
        cmp_oeb   = 1'b1;
        cmp_addr  = r_q.addr[ROW_AW-1:0];
        cmp_wmask = '1;
        cmp_wdata = dat_rdata;
        cmp_alg   = 3'd0;
        cma_csb   = 1'b1;
        cma_web   = 1'b1;
        cma_oeb   = 1'b1;
        cma_addr  = cptr[CMD_AW-1:0];
        cma_wdata = dat_rdata;

        case (r_q.st)
            S_IDLE: begin
                if (req_valid) begin
                    r_d.addr    = req_addr;
                    r_d.wdata   = req_wdata;
                    r_d.cnt     = clip;
                    r_d.is_load = (req_code == OP_CMDLD);
                    r_d.alg     = req_code - OP_ALG_BASE;
                    if (req_code == OP_STORE) begin
                        r_d.st = S_STORE;
                    end else if (req_code == OP_COPY || req_code == OP_CMDLD) begin
                        r_d.st = S_TAG;
                    end else begin
                        r_d.st    = S_RUN;
                        run_start = 1'b1;
                    end
                end
            end
            S_STORE: begin
                cmp_csb   = 1'b0;
                cmp_web   = 1'b0;
                cmp_addr  = sp[ST_AW-1:LANE_AW];
                cmp_wmask = LANES'(1) << sp[LANE_AW-1:0];
                cmp_wdata = {LANES{r_q.wdata}};
                st_step   = 1'b1;
                r_d.st    = S_DONE;
            end
            S_TAG:  r_d.st = tag_hit  ? S_RD : S_WAIT;
            S_WAIT: r_d.st = miss_ret ? S_RD : S_WAIT;
            S_RD: begin
                dat_csb = 1'b0;
                dat_oeb = 1'b0;
                r_d.st  = S_WR;
            end
            S_WR: begin
                if (r_q.is_load) begin
                    cma_csb  = 1'b0;
                    cma_web  = 1'b0;
                    cma_addr = {slot, {CPL_AW{1'b0}}};
                    ld_en    = 1'b1;
                end else begin
                    cmp_csb = 1'b0;
                    cmp_web = 1'b0;
                end
                r_d.st = S_DONE;
            end
            S_RUN: begin
                cmp_alg = r_q.alg;
                if (rd_go) begin
                    cma_csb = 1'b0;
                    cma_oeb = 1'b0;
                end
                if (!more) r_d.st = S_RES_RD;
            end
            S_RES_RD: begin
                cmp_csb = 1'b0;
                cmp_oeb = 1'b0;
                r_d.st  = S_RES_WR;
            end
            S_RES_WR: begin
                dat_csb = 1'b0;
                dat_web = 1'b0;
                run_end = 1'b1;
                r_d.st  = S_DONE;
            end
            S_DONE: begin
                done   = 1'b1;
                r_d.st = S_IDLE;
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= S_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4
    miss_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_WAIT && !miss_ret) |=> dat_csb);

    // R5
    copy_adjacent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dat_csb && !dat_oeb) |=> (!cmp_web || !cma_web));

    // R9
    result_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dat_csb && !dat_web) |-> $past(!cmp_csb && !cmp_oeb));

    // R10
    idle_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_DONE) |=> (r_q.st == S_IDLE));

    // R8
    cmd_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_cmd_vld |-> $past(!cma_csb && !cma_oeb));

endmodule

// File: tb/sim_nsc_sequencer.sv
module sim_nsc_sequencer;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic [2:0]   req_code = 3'd0;
    logic [15:0]  req_addr = '0;
    logic [31:0]  req_wdata = '0;
    logic [15:0]  req_count = '0;
    logic         tag_hit = 1'b0;
    logic         miss_ret = 1'b0;
    logic         dat_csb, dat_web, dat_oeb;
    logic [15:0]  dat_addr;
    logic [511:0] dat_wdata;
    logic [511:0] dat_rdata = '0;
    logic         cmp_csb, cmp_web, cmp_oeb;
    logic [7:0]   cmp_addr;
    logic [15:0]  cmp_wmask;
    logic [511:0] cmp_wdata;
    logic [511:0] cmp_rdata = '0;
    logic [15:0]  cmp_cmd;
    logic         cmp_cmd_vld;
    logic [2:0]   cmp_alg;
    logic         cma_csb, cma_web, cma_oeb;
    logic [12:0]  cma_addr;
    logic [511:0] cma_wdata;
    logic [15:0]  cma_rdata = '0;
    logic         done;

    int          n_chk = 0;
    int          n_fail = 0;
    bit          finished = 1'b0;
    logic [11:0] exp_sp = '0;

    always #10 clk = ~clk;

    nsc_sequencer u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_code(req_code),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_count(req_count),
        .tag_hit(tag_hit), .miss_ret(miss_ret),
        .dat_csb(dat_csb), .dat_web(dat_web), .dat_oeb(dat_oeb), .dat_addr(dat_addr),
        .dat_wdata(dat_wdata), .dat_rdata(dat_rdata),
        .cmp_csb(cmp_csb), .cmp_web(cmp_web), .cmp_oeb(cmp_oeb), .cmp_addr(cmp_addr),
        .cmp_wmask(cmp_wmask), .cmp_wdata(cmp_wdata), .cmp_rdata(cmp_rdata),
        .cmp_cmd(cmp_cmd), .cmp_cmd_vld(cmp_cmd_vld), .cmp_alg(cmp_alg),
        .cma_csb(cma_csb), .cma_web(cma_web), .cma_oeb(cma_oeb), .cma_addr(cma_addr),
        .cma_wdata(cma_wdata), .cma_rdata(cma_rdata), .done(done)
    );

    function automatic logic [511:0] dline(input logic [15:0] a);
        logic [511:0] v;
        for (int l = 0; l < 16; l++) v[l*32 +: 32] = {a, 8'hD0, 4'h0, 4'(l)};
        return v;
    endfunction

    function automatic logic [511:0] cline(input logic [7:0] row);
        logic [511:0] v;
        for (int l = 0; l < 16; l++) v[l*32 +: 32] = {16'hC0DE, row, 4'(l), 4'h0};
        return v;
    endfunction

    function automatic logic [15:0] cpat(input logic [12:0] a);
        return {3'b101, a};
    endfunction

    // Synchronous array models: read data one cycle after the read strobe
    always_ff @(posedge clk) begin
        if (!dat_csb && !dat_oeb) dat_rdata <= dline(dat_addr);
        if (!cmp_csb && !cmp_oeb) cmp_rdata <= cline(cmp_addr);
        if (!cma_csb && !cma_oeb) cma_rdata <= cpat(cma_addr);
    end

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send(input logic [2:0] code, input logic [15:0] addr,
                        input logic [31:0] wd, input logic [15:0] cnt);
        req_code  = code;
        req_addr  = addr;
        req_wdata = wd;
        req_count = cnt;
        req_valid = 1'b1;
        tick();
        req_valid = 1'b0;
    endtask

    task automatic t_reset;
        // R1
        chk({dat_csb, dat_web, dat_oeb} == 3'b111, "R1 data strobes", 64'({dat_csb, dat_web, dat_oeb}), 64'h7);
        chk({cmp_csb, cmp_web, cmp_oeb} == 3'b111, "R1 compute strobes", 64'({cmp_csb, cmp_web, cmp_oeb}), 64'h7);
        chk({cma_csb, cma_web, cma_oeb} == 3'b111, "R1 command strobes", 64'({cma_csb, cma_web, cma_oeb}), 64'h7);
        chk(done == 1'b0 && cmp_cmd_vld == 1'b0, "R1 done/valid low", 64'({done, cmp_cmd_vld}), 64'h0);
    endtask

    task automatic t_store(input logic [31:0] wd);
        send(3'd0, 16'h0000, wd, 16'd0);
        // R3, R2: store goes to the compute array at the pointer
        chk(!cmp_csb && !cmp_web, "R3 store strobe", 64'({cmp_csb, cmp_web}), 64'h0);
        chk(cmp_addr == exp_sp[11:4], "R3 store row", 64'(cmp_addr), 64'(exp_sp[11:4]));
        chk(cmp_wmask == (16'h1 << exp_sp[3:0]), "R3 store lane", 64'(cmp_wmask), 64'(16'h1 << exp_sp[3:0]));
        chk(cmp_wdata == {16{wd}}, "R3 store word", cmp_wdata[63:0], {wd, wd});
        chk(dat_csb == 1'b1, "R3 data array untouched", 64'(dat_csb), 64'h1);
        tick();
        chk(done == 1'b1, "R10 store done", 64'(done), 64'h1);
        tick();
        chk(done == 1'b0, "R10 done one cycle", 64'(done), 64'h0);
        exp_sp = exp_sp + 1'b1;
    endtask

    task automatic t_busy_ignore;
        tag_hit   = 1'b1;
        req_code  = 3'd0;
        req_wdata = 32'hFEED_0001;
        req_valid = 1'b1;
        tick();
        req_code = 3'd1;
        tick();
        req_valid = 1'b0;
        exp_sp = exp_sp + 1'b1;
        for (int i = 0; i < 3; i++) begin
            tick();
            // R10: the copy presented during the store must not start
            chk(dat_csb == 1'b1 && done == 1'b0, "R10 busy request ignored",
                64'({dat_csb, done}), 64'h2);
        end
    endtask

    task automatic fetch(input logic [2:0] code, input logic [15:0] addr, input bit hit,
                         input int waitc, input logic [15:0] cnt, input logic [7:0] exp_slot);
        tag_hit  = hit;
        miss_ret = 1'b0;
        send(code, addr, 32'h0, cnt);
        chk(dat_csb == 1'b1, "R4 tag cycle quiet", 64'(dat_csb), 64'h1);
        if (!hit) begin
            for (int i = 0; i < waitc; i++) begin
                tick();
                // R4: stall on miss
                chk(dat_csb == 1'b1, "R4 miss stall", 64'(dat_csb), 64'h1);
            end
            miss_ret = 1'b1;
        end
        tick();
        miss_ret = 1'b0;
        chk(!dat_csb && !dat_oeb && dat_web, "R4 line read", 64'({dat_csb, dat_oeb, dat_web}), 64'h1);
        chk(dat_addr == addr, "R5 read address", 64'(dat_addr), 64'(addr));
        tick();
        if (code == 3'd1) begin
            // R5: write in the adjacent cycle
            chk(!cmp_csb && !cmp_web, "R5 compute write", 64'({cmp_csb, cmp_web}), 64'h0);
            chk(cmp_addr == addr[7:0] && cmp_wmask == 16'hFFFF, "R5 row and lanes",
                64'({cmp_addr, cmp_wmask}), 64'({addr[7:0], 16'hFFFF}));
            chk(cmp_wdata == dline(addr), "R5 line data", cmp_wdata[63:0], dline(addr) >> 0);
        end else begin
            // R6: command memory slot
            chk(!cma_csb && !cma_web && cmp_csb, "R6 command write", 64'({cma_csb, cma_web, cmp_csb}), 64'h1);
            chk(cma_addr == {exp_slot, 5'd0}, "R6 slot address", 64'(cma_addr), 64'({exp_slot, 5'd0}));
            chk(cma_wdata == dline(addr), "R6 line data", cma_wdata[63:0], dline(addr) >> 0);
        end
        tick();
        chk(done == 1'b1, "R10 fetch done", 64'(done), 64'h1);
        tick();
    endtask

    task automatic t_exec(input logic [2:0] code, input logic [15:0] addr, input int n);
        int errs;
        errs = 0;
        send(code, addr, 32'h0, 16'd0);
        for (int c = 1; c <= n + 1; c++) begin
            if (c <= n) begin
                if (cma_csb || cma_oeb || cma_addr != 13'(c - 1)) errs++;
            end else if (!cma_csb) errs++;
            if (c >= 2) begin
                if (!cmp_cmd_vld || cmp_cmd != cpat(13'(c - 2))) errs++;
            end else if (cmp_cmd_vld) errs++;
            if (cmp_alg != code - 3'd3) errs++;
            if (c < n + 1) tick();
        end
        // R8, R2
        chk(errs == 0, "R8 command replay order", 64'(errs), 64'h0);
        tick();
        // R9
        chk(!cmp_csb && !cmp_oeb && cmp_addr == addr[7:0], "R9 result row read",
            64'({cmp_csb, cmp_oeb, cmp_addr}), 64'({2'b00, addr[7:0]}));
        tick();
        chk(!dat_csb && !dat_web && dat_addr == addr, "R9 result write",
            64'({dat_csb, dat_web, dat_addr}), 64'({2'b00, addr}));
        chk(dat_wdata == cline(addr[7:0]), "R9 result data", dat_wdata[63:0], cline(addr[7:0]) >> 0);
        tick();
        chk(done == 1'b1, "R10 exec done", 64'(done), 64'h1);
        tick();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        tick();
        t_reset();
        t_store(32'h1111_2222);
        t_store(32'h3333_4444);
        t_store(32'hA5A5_5A5A);
        t_busy_ignore();
        fetch(3'd1, 16'h1234, 1'b1, 0, 16'd0, 8'd0);
        fetch(3'd1, 16'h00A5, 1'b0, 3, 16'd0, 8'd0);
        fetch(3'd2, 16'h0200, 1'b1, 0, 16'd3, 8'd0);
        fetch(3'd2, 16'h0201, 1'b0, 1, 16'd5, 8'd1);
        t_exec(3'd4, 16'h0300, 5);
        // R6: slot rewinds after execution; R8: zero count
        fetch(3'd2, 16'h0202, 1'b1, 0, 16'd0, 8'd0);
        t_exec(3'd3, 16'h0411, 0);
        // R7: count clipped to 8192
        fetch(3'd2, 16'h0203, 1'b1, 0, 16'd20000, 8'd0);
        t_exec(3'd7, 16'h05FE, 8192);
        // R3: pointer wrap
        while (exp_sp != 12'hFFF) t_store(32'(exp_sp));
        t_store(32'hDEAD_BEEF);
        chk(exp_sp == 12'h000, "R3 bench pointer wrapped", 64'(exp_sp), 64'h0);
        t_store(32'h0BAD_F00D);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R10 actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule